// File: doc/BRIEF.md
# Eight-Operation 4-Bit Arithmetic Unit

This block computes one result per clock for a small accumulator-style datapath. A 3-bit operation code, taken straight from the instruction opcode field, selects among a constant, an increment, a decrement, a two-operand sum and several pass-through operations. Both operands are unsigned and 4 bits wide by default. Every result wraps modulo 2^WIDTH. A zero flag reports when the result is all zeros.

All arithmetic goes through one ripple-carry adder that has a carry input. For an increment the adder's second input is forced to all zeros and its carry-in to 1. For a decrement the second input is forced to all ones and the carry-in to 0. For the sum the second input is operand B and the carry-in is 0. Operations that use one operand read it from operand A. The result and the zero flag are registered, so they appear one clock after the inputs are sampled.

Top module: `alu8_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next outputs are `result_o` = 0 and `zero_o` = 1.
- R2: Code 3'b001 gives a result of 1 (0001), whatever A and B are.
- R3: Code 3'b010 gives (A + 1) mod 16. Incrementing 15 gives 0, and incrementing 4 gives 5.
- R4: Code 3'b011 gives (A + 15) mod 16, which is A − 1 with wrap-around. Decrementing 0 gives 15, and decrementing 1 gives 0.
- R5: Code 3'b110 gives (A + B) mod 16. For example, 2 + 4 gives 6 and 15 + 1 gives 0.
- R6: Codes 3'b000, 3'b100, 3'b101 and 3'b111 give A unchanged, and B has no effect on the result.
- R7: `zero_o` is 1 exactly when `result_o` is 0000.
- R8: The outputs take the values computed from `op_i`, `a_i` and `b_i` as they are sampled at one rising edge. They change at that edge and hold until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 3 | Operation code (the instruction opcode field) |
| a_i | input | WIDTH | Operand A; the source for single-operand operations |
| b_i | input | WIDTH | Operand B; used only by the sum |
| result_o | output | WIDTH | Registered result |
| zero_o | output | 1 | Registered zero flag |

## Verification
The hardest cases to reach are those where a carry or borrow runs through every bit of the adder: incrementing 15, decrementing 0, and 15 + 1. Each of these wraps to a result whose zero flag must match. The bench drives these corners first and then sweeps every code against every pair of operand values. That sweep also shows that B has no effect on the pass-through codes and the constant code. A reset applied in the middle of the run confirms that the output register clears no matter which operation it last held.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'b000,
    OP_ONE   = 3'b001,
    OP_INC   = 3'b010,
    OP_DEC   = 3'b011,
    OP_FETCH = 3'b100,
    OP_EMIT  = 3'b101,
    OP_SUM   = 3'b110,
    OP_MOVE  = 3'b111
  } alu_op_e;

endpackage

// File: rtl/alu8_steer.sv
// Chooses the adder's second input and its carry-in for each operation.
module alu8_steer
  import alu8_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] addend,
  output logic             cin
);

  always_comb begin
    addend = b;
    cin    = 1'b0;
    unique case (alu_op_e'(op))
      OP_INC: begin
        addend = '0;
        cin    = 1'b1;
      end
      OP_DEC: begin
        addend = '1;
        cin    = 1'b0;
      end
      default: begin
        addend = b;
        cin    = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu8_adder.sv
// Ripple-carry adder. The carry out of the top bit is not kept, so results wrap.
module alu8_adder #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum
);

  logic [WIDTH-1:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum[i] = x[i] ^ y[i] ^ carry[i];
    if (i < WIDTH - 1) begin : g_carry
      assign carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
    end
  end

endmodule

// File: rtl/alu8_select.sv
// Chooses the final result: the constant, the adder output, or operand A.
module alu8_select
  import alu8_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] sum,
  output logic [WIDTH-1:0] res
);

  localparam logic [WIDTH-1:0] CONST_ONE = WIDTH'(1);

  always_comb begin
    unique case (alu_op_e'(op))
      OP_ONE:                 res = CONST_ONE;
      OP_INC, OP_DEC, OP_SUM: res = sum;
      default:                res = a;
    endcase
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o
);

  logic [WIDTH-1:0] addend;
  logic             cin;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] res_next;

  alu8_steer #(.WIDTH(WIDTH)) steer_i (
    .op     (op_i),
    .b      (b_i),
    .addend (addend),
    .cin    (cin)
  );

  alu8_adder #(.WIDTH(WIDTH)) adder_i (
    .x   (a_i),
    .y   (addend),
    .cin (cin),
    .sum (sum)
  );

  alu8_select #(.WIDTH(WIDTH)) select_i (
    .op  (op_i),
    .a   (a_i),
    .sum (sum),
    .res (res_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      zero_o   <= 1'b1;
    end else begin
      result_o <= res_next;
      zero_o   <= (res_next == '0);
    end
  end

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (result_o == '0 && zero_o));

  p_const_one_r2: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b001) |=> (result_o == WIDTH'(1)));

  p_increment_r3: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b010) |=> (result_o == WIDTH'($past(a_i) + 1'b1)));

  p_decrement_r4: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b011) |=> (result_o == WIDTH'($past(a_i) - 1'b1)));

  p_sum_r5: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b110) |=> (result_o == WIDTH'($past(a_i) + $past(b_i))));

  p_pass_a_r6: assert property (@(posedge clk) disable iff (rst)
    (op_i inside {3'b000, 3'b100, 3'b101, 3'b111}) |=> (result_o == $past(a_i)));

  p_zero_flag_r7: assert property (@(posedge clk) disable iff (rst)
    zero_o == (result_o == '0));

endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/alu8_core_tb_top.sv
`timescale 1ns/1ps
module alu8_core_tb_top;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   op_i = 3'b000;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic [W-1:0] result_o;
  logic         zero_o;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  int    exp_res;
  bit    exp_zero;
  bit    exp_valid = 1'b0;
  string exp_tag;

  always #2.5 clk = ~clk;

  alu8_core #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .result_o(result_o), .zero_o(zero_o)
  );

  function automatic int model(input int op, input int a, input int b);
    case (op)
      1:       return 1;
      2:       return (a + 1) % 16;
      3:       return (a + 15) % 16;
      6:       return (a + b) % 16;
      default: return a;
    endcase
  endfunction

  function automatic string tag_of(input int op);
    case (op)
      1:       return "R2";
      2:       return "R3";
      3:       return "R4";
      6:       return "R5";
      default: return "R6";
    endcase
  endfunction

  // Reference: work out what the edge should produce. The outputs settle
  // after this edge and are compared at the following falling edge (R8).
  always @(posedge clk) begin
    if (rst) begin
      exp_res = 0;
      exp_tag = "R1";
    end else begin
      exp_res = model(int'(op_i), int'(a_i), int'(b_i));
      exp_tag = tag_of(int'(op_i));
    end
    exp_zero  = (exp_res == 0);
    exp_valid = 1'b1;
  end

  always @(negedge clk) begin
    if (exp_valid && !done) begin
      vectors++;
      if (int'(result_o) != exp_res) begin
        misses++;
        $display("FAIL %s+R8 result: actual %0d expected %0d", exp_tag, result_o, exp_res);
      end
      vectors++;
      if (zero_o != exp_zero) begin
        misses++;
        $display("FAIL R7 zero flag: actual %0b expected %0b", zero_o, exp_zero);
      end
    end
  end

  task automatic drive(input int op, input int a, input int b);
    @(negedge clk);
    op_i = 3'(op);
    a_i  = W'(a);
    b_i  = W'(b);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    drive(2, 4, 9);
    drive(3, 1, 7);
    drive(6, 2, 4);
    drive(2, 15, 0);
    drive(3, 0, 5);
    drive(6, 15, 1);
    drive(1, 0, 0);
    drive(1, 12, 15);
    drive(5, 9, 3);
    drive(7, 0, 15);
    drive(0, 11, 2);
    drive(4, 6, 6);
    drive(3, 8, 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          drive(op, a, b);
    drive(2, 15, 15);
    drive(6, 9, 7);
    repeat (2) @(negedge clk);
    #1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule